// File: doc/BRIEF.md
# Bus-Mastering LCD Refresh Engine

This block keeps a monochrome dot-matrix panel refreshed from a packed frame buffer in system memory, with no processor involvement. It raises a bus request, waits for the grant and then reads a fixed-length burst of frame-buffer words into a small on-chip FIFO. A scan engine takes the FIFO words one at a time, breaks each into 4-pixel nibbles and sends them to the column driver together with a shift clock. After each line it produces the line latch, the row advance clock, the first-line marker and an alternating frame polarity signal.

The frame buffer holds one bit per pixel, 32 pixels to a word. With the default parameters a line is 4 words wide, and 128 lines form a 512-word frame. The fetch address is made of a base field that software supplies on the upper address bits and a word counter on the bits below it, which sits directly above the two byte-offset bits. If memory is slow, the scan engine pauses its shift clock rather than repeating old pixels.

Top module: `lcd_refresh`

## Requirements
- R1: While reset is held, every bus and panel output is low and the fetch address is the base field followed by a word count of zero.
- R2: The bus request rises only when the FIFO has room for a whole burst (occupancy at most FIFO_DEPTH - BURST). The read strobe is high only while the request is high and the grant has been received.
- R3: The fetch address is {base, word_count, 2'b00}. The word count advances by one on every acknowledged read, holds when there is no acknowledge, and wraps from WORDS_PER_LINE*LINES-1 to 0.
- R4: Each grant yields exactly BURST acknowledged reads. After the last one, the read strobe and the request fall together.
- R5: Pixels leave most significant bit first. The first nibble of a word is bits 31:28 and the last is bits 3:0. Data bit 3 is the leftmost pixel of the nibble, and the data is stable while the shift clock is high.
- R6: A line is exactly WORDS_PER_LINE*8 shift clock pulses, followed by a one-cycle latch pulse that never overlaps the shift clock. A one-cycle row clock pulse follows in the next cycle.
- R7: The first-line marker is high during the latch and row clock pulses of line 0, and at no other time.
- R8: The frame polarity changes only together with the row clock that ends the last line (LINES-1), so it toggles once per frame.
- R9: When the FIFO is empty and the current word has been used up, the shift clock stays low. No pulse is ever issued beyond the pixels actually fetched.
- R10: The FIFO is never written while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_base_i | input | ADDR_W-2-log2(WORDS_PER_LINE*LINES) | Frame-buffer base field (upper address bits) |
| bus_gnt_i | input | 1 | Bus grant, held for the whole burst |
| bus_ack_i | input | 1 | Read acknowledge; read data valid |
| bus_rdata_i | input | DATA_W | Read data |
| bus_req_o | output | 1 | Bus request |
| bus_rd_o | output | 1 | Read strobe |
| bus_addr_o | output | ADDR_W | Byte address of the word being read |
| lcd_data_o | output | 4 | Four pixels to the column driver |
| lcd_sclk_o | output | 1 | Column data shift clock |
| lcd_latch_o | output | 1 | Line latch pulse |
| lcd_frame_o | output | 1 | Frame polarity for AC drive |
| lcd_first_o | output | 1 | First-line marker |
| lcd_rowclk_o | output | 1 | Row driver shift clock |

## Verification
The hardest state to reach is the underrun. The FIFO must drain completely while the scan engine is part-way through a line, and then the stream must resume with the correct pixel. The bench holds back the grant for several hundred cycles on chosen bursts. It then confirms that the shift clock has been idle for a long stretch before the delayed data arrives, and that every pixel after the gap still matches the address-derived pattern. The grant delays and acknowledge gaps are varied so that bursts start at different points of a line and of a frame.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;
    typedef enum logic [1:0] {F_IDLE, F_REQ, F_XFER} fetch_st_e;
    typedef enum logic [1:0] {S_LO, S_HI, S_LATCH, S_ROW} scan_st_e;
endpackage

// File: rtl/lcd_fifo.sv
module lcd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rdata_o,
    output logic [$clog2(DEPTH):0]     count_o
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [PTR_W:0]   cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (push_i) d.wp = q.wp + 1'b1;
        if (pop_i)  d.rp = q.rp + 1'b1;
        case ({push_i, pop_i})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (push_i) mem[q.wp] <= wdata_i;
    end

    assign rdata_o = mem[q.rp];
    assign count_o = q.cnt;
endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch
    import lcd_refresh_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FRAME_WORDS = 512,
    parameter int DEPTH       = 8,
    parameter int BURST       = 4
) (
    input  logic                                      clk_i,
    input  logic                                      rst_ni,
    input  logic [ADDR_W-3-$clog2(FRAME_WORDS):0]     base_i,
    input  logic                                      gnt_i,
    input  logic                                      ack_i,
    input  logic [$clog2(DEPTH):0]                    fifo_cnt_i,
    output logic                                      req_o,
    output logic                                      rd_o,
    output logic                                      push_o,
    output logic [ADDR_W-1:0]                         addr_o
);
    localparam int CNT_W  = $clog2(FRAME_WORDS);
    localparam int CF_W   = $clog2(DEPTH) + 1;
    localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1;
    localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(FRAME_WORDS - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST - 1);
    localparam logic [CF_W-1:0]   ROOM      = CF_W'(DEPTH - BURST);

    typedef struct packed {
        fetch_st_e         st;
        logic [CNT_W-1:0]  wcnt;
        logic [BEAT_W-1:0] beat;
    } fetch_t;

    fetch_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            F_IDLE: if (fifo_cnt_i <= ROOM) d.st = F_REQ;
            F_REQ:  if (gnt_i) d.st = F_XFER;
            F_XFER: if (ack_i) begin
                d.wcnt = (q.wcnt == LAST_WORD) ? '0 : q.wcnt + 1'b1;
                if (q.beat == LAST_BEAT) begin
                    d.beat = '0;
                    d.st   = F_IDLE;
                end else begin
                    d.beat = q.beat + 1'b1;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: F_IDLE, wcnt: '0, beat: '0};
        else         q <= d;
    end

    assign req_o  = (q.st != F_IDLE);
    assign rd_o   = (q.st == F_XFER);
    assign push_o = rd_o && ack_i;
    assign addr_o = {base_i, q.wcnt, 2'b00};
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
    import lcd_refresh_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int NIB_W          = 4,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              pop_o,
    output logic [NIB_W-1:0]  data_o,
    output logic              sclk_o,
    output logic              latch_o,
    output logic              frame_o,
    output logic              first_o,
    output logic              rowclk_o
);
    localparam int NPW    = DATA_W / NIB_W;
    localparam int NPL    = NPW * WORDS_PER_LINE;
    localparam int LEFT_W = $clog2(NPW + 1);
    localparam int COL_W  = $clog2(NPL);
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NPL - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    typedef struct packed {
        scan_st_e          st;
        logic [DATA_W-1:0] sreg;
        logic [LEFT_W-1:0] left;
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
        logic              frame;
        logic [NIB_W-1:0]  dq;
        logic              sclk;
        logic              lp;
        logic              rclk;
        logic              first;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d       = q;
        pop_o   = 1'b0;
        d.sclk  = 1'b0;
        d.lp    = 1'b0;
        d.rclk  = 1'b0;
        d.first = 1'b0;
        case (q.st)
            S_LO: begin
                if (q.left != '0) begin
                    d.dq   = q.sreg[DATA_W-1 -: NIB_W];
                    d.sreg = q.sreg << NIB_W;
                    d.left = q.left - 1'b1;
                    d.st   = S_HI;
                end else if (!empty_i) begin
                    pop_o  = 1'b1;
                    d.dq   = word_i[DATA_W-1 -: NIB_W];
                    d.sreg = word_i << NIB_W;
                    d.left = LEFT_W'(NPW - 1);
                    d.st   = S_HI;
                end
            end
            S_HI: begin
                d.sclk = 1'b1;
                if (q.col == LAST_COL) begin
                    d.col = '0;
                    d.st  = S_LATCH;
                end else begin
                    d.col = q.col + 1'b1;
                    d.st  = S_LO;
                end
            end
            S_LATCH: begin
                d.lp    = 1'b1;
                d.first = (q.line == '0);
                d.st    = S_ROW;
            end
            S_ROW: begin
                d.rclk  = 1'b1;
                d.first = (q.line == '0);
                if (q.line == LAST_LINE) begin
                    d.line  = '0;
                    d.frame = ~q.frame;
                end else begin
                    d.line = q.line + 1'b1;
                end
                d.st = S_LO;
            end
            default: d.st = S_LO;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: S_LO, default: '0};
        else         q <= d;
    end

    assign data_o   = q.dq;
    assign sclk_o   = q.sclk;
    assign latch_o  = q.lp;
    assign frame_o  = q.frame;
    assign first_o  = q.first;
    assign rowclk_o = q.rclk;
endmodule

// File: rtl/lcd_refresh.sv
module lcd_refresh #(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 128,
    parameter int FIFO_DEPTH     = 8,
    parameter int BURST          = 4
) (
    input  logic                                                  clk_i,
    input  logic                                                  rst_ni,
    input  logic [ADDR_W-3-$clog2(WORDS_PER_LINE*LINES):0]        fb_base_i,
    input  logic                                                  bus_gnt_i,
    input  logic                                                  bus_ack_i,
    input  logic [DATA_W-1:0]                                     bus_rdata_i,
    output logic                                                  bus_req_o,
    output logic                                                  bus_rd_o,
    output logic [ADDR_W-1:0]                                     bus_addr_o,
    output logic [3:0]                                            lcd_data_o,
    output logic                                                  lcd_sclk_o,
    output logic                                                  lcd_latch_o,
    output logic                                                  lcd_frame_o,
    output logic                                                  lcd_first_o,
    output logic                                                  lcd_rowclk_o
);
    localparam int FRAME_WORDS = WORDS_PER_LINE * LINES;
    localparam int CF_W        = $clog2(FIFO_DEPTH) + 1;

    logic              fifo_push;
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_word;
    logic [CF_W-1:0]   fifo_cnt;

    lcd_fetch #(
        .ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS),
        .DEPTH(FIFO_DEPTH), .BURST(BURST)
    ) u_fetch (
        .clk_i(clk_i), .rst_ni(rst_ni), .base_i(fb_base_i),
        .gnt_i(bus_gnt_i), .ack_i(bus_ack_i), .fifo_cnt_i(fifo_cnt),
        .req_o(bus_req_o), .rd_o(bus_rd_o), .push_o(fifo_push),
        .addr_o(bus_addr_o)
    );

    lcd_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(fifo_push),
        .wdata_i(bus_rdata_i), .pop_i(fifo_pop), .rdata_o(fifo_word),
        .count_o(fifo_cnt)
    );

    lcd_scan #(
        .DATA_W(DATA_W), .NIB_W(4),
        .WORDS_PER_LINE(WORDS_PER_LINE), .LINES(LINES)
    ) u_scan (
        .clk_i(clk_i), .rst_ni(rst_ni), .empty_i(fifo_cnt == '0),
        .word_i(fifo_word), .pop_o(fifo_pop), .data_o(lcd_data_o),
        .sclk_o(lcd_sclk_o), .latch_o(lcd_latch_o), .frame_o(lcd_frame_o),
        .first_o(lcd_first_o), .rowclk_o(lcd_rowclk_o)
    );
endmodule

// File: rtl/lcd_refresh_chk.sv
module lcd_refresh_chk #(
    parameter int ADDR_W      = 32,
    parameter int FRAME_WORDS = 512,
    parameter int DEPTH       = 8,
    parameter int BURST       = 4
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     bus_req_o,
    input logic                     bus_rd_o,
    input logic                     bus_gnt_i,
    input logic                     bus_ack_i,
    input logic [ADDR_W-1:0]        bus_addr_o,
    input logic [3:0]               lcd_data_o,
    input logic                     lcd_sclk_o,
    input logic                     lcd_latch_o,
    input logic                     lcd_frame_o,
    input logic                     lcd_first_o,
    input logic                     lcd_rowclk_o,
    input logic                     fifo_push,
    input logic [$clog2(DEPTH):0]   fifo_cnt
);
    localparam int CNT_W = $clog2(FRAME_WORDS);
    localparam int CF_W  = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(FRAME_WORDS - 1);
    localparam logic [CF_W-1:0]  ROOM      = CF_W'(DEPTH - BURST);
    localparam logic [CF_W-1:0]  FULL      = CF_W'(DEPTH);

    wire [CNT_W-1:0] wfield = bus_addr_o[CNT_W+1:2];

    p_req_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_req_o) |-> $past(fifo_cnt) <= ROOM);
    p_rd_has_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rd_o |-> bus_req_o);
    p_rd_after_gnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_rd_o) |-> $past(bus_gnt_i));
    p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_o && bus_ack_i) |=>
        wfield == (($past(wfield) == LAST_WORD) ? '0 : $past(wfield) + 1'b1));
    p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_o && !bus_ack_i) |=> $stable(bus_addr_o));
    p_data_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lcd_sclk_o |-> $stable(lcd_data_o));
    p_latch_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lcd_latch_o |=> (!lcd_latch_o && lcd_rowclk_o));
    p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lcd_sclk_o && lcd_latch_o));
    p_first_in_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lcd_first_o |-> (lcd_latch_o || lcd_rowclk_o));
    p_frame_on_row_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lcd_frame_o != $past(lcd_frame_o)) |-> lcd_rowclk_o);
    p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_push |-> fifo_cnt < FULL);
endmodule

bind lcd_refresh lcd_refresh_chk #(
    .ADDR_W(ADDR_W), .FRAME_WORDS(WORDS_PER_LINE*LINES),
    .DEPTH(FIFO_DEPTH), .BURST(BURST)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_o(bus_req_o), .bus_rd_o(bus_rd_o),
    .bus_gnt_i(bus_gnt_i), .bus_ack_i(bus_ack_i), .bus_addr_o(bus_addr_o),
    .lcd_data_o(lcd_data_o), .lcd_sclk_o(lcd_sclk_o), .lcd_latch_o(lcd_latch_o),
    .lcd_frame_o(lcd_frame_o), .lcd_first_o(lcd_first_o),
    .lcd_rowclk_o(lcd_rowclk_o), .fifo_push(fifo_push), .fifo_cnt(fifo_cnt)
);

// File: tb/lcd_refresh_bench.sv
`timescale 1ns/1ps
module lcd_refresh_bench;
    localparam int WPL    = 4;
    localparam int LINES  = 8;
    localparam int DEPTH  = 8;
    localparam int BURST  = 4;
    localparam int FRAME  = WPL * LINES;
    localparam int CNT_W  = $clog2(FRAME);
    localparam int BASE_W = 32 - 2 - CNT_W;
    localparam int NPL    = WPL * 8;
    localparam logic [BASE_W-1:0] BASE = BASE_W'(25'h0ABCDE1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0, ack = 1'b0;
    logic [31:0] rdata = '0;
    logic req, rd, sclk, lp, frame, first, rowclk;
    logic [31:0] addr;
    logic [3:0] data;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    lcd_refresh #(
        .WORDS_PER_LINE(WPL), .LINES(LINES), .FIFO_DEPTH(DEPTH), .BURST(BURST)
    ) u_lcd_refresh (
        .clk_i(clk), .rst_ni(rst_n), .fb_base_i(BASE), .bus_gnt_i(gnt),
        .bus_ack_i(ack), .bus_rdata_i(rdata), .bus_req_o(req), .bus_rd_o(rd),
        .bus_addr_o(addr), .lcd_data_o(data), .lcd_sclk_o(sclk),
        .lcd_latch_o(lp), .lcd_frame_o(frame), .lcd_first_o(first),
        .lcd_rowclk_o(rowclk)
    );

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] addr_of(input int w);
        return {BASE, CNT_W'(w % FRAME), 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
        end
    endtask

    initial begin
        int  acks = 0, beats = 0, bursts = 0, wait_cnt = 0, idle = 0;
        int  nib = 0, col = 0, line = 0, lines_done = 0, cyc = 0;
        bit  prev_rd = 0, prev_sclk = 0, prev_lp = 0, prev_row = 0, prev_ack = 0;
        bit  exp_frame = 0, long_wait = 0, done = 0;
        logic [15:0] lfsr = 16'hACE1;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!req && !rd, "R1 bus idle", {req, rd}, 0);
        chk(!sclk && !lp && !frame && !first && !rowclk && data == 0, "R1 panel idle",
            {data, sclk, lp, frame, first, rowclk}, 0);
        chk(addr == addr_of(0), "R1 address", addr, addr_of(0));
        rst_n = 1'b1;

        while (!done) begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (prev_rd && prev_ack) begin
                acks++;
                beats++;
            end
            // bus side
            if (rd) begin
                chk(req && gnt, "R2 strobe needs request and grant", {req, gnt}, 3);
                chk(addr == addr_of(acks), "R3 fetch address", addr, addr_of(acks));
            end
            if (prev_rd && !rd) begin
                chk(beats == BURST, "R4 beats per grant", beats, BURST);
                chk(!req, "R4 request released", req, 0);
                beats = 0;
                bursts++;
                gnt = 1'b0;
                long_wait = (bursts == 10 || bursts == 30);
                wait_cnt = long_wait ? 300 : int'(lfsr[1:0]);
            end else if (req && !gnt) begin
                if (wait_cnt == 0) begin
                    if (long_wait) begin
                        // R9: panel must have stalled during the long hold-off
                        chk(idle >= 100, "R9 shift clock stalled while starved", idle, 100);
                        long_wait = 0;
                    end
                    gnt = 1'b1;
                end else begin
                    wait_cnt--;
                end
            end
            ack   = rd && (lfsr[3:2] != 2'b00);
            rdata = ack ? word_at(addr) : 32'hDEAD_BEEF;
            prev_ack = ack;
            prev_rd  = rd;

            // panel side
            idle = sclk ? 0 : idle + 1;
            if (sclk && !prev_sclk) begin
                logic [31:0] w;
                logic [3:0]  e;
                w = word_at(addr_of(nib / 8));
                e = w[31 - 4 * (nib % 8) -: 4];
                chk(data == e, "R5 pixel nibble", data, e);
                chk(nib < acks * 8, "R9 no pulse beyond fetched data", nib, acks * 8);
                nib++;
                col++;
            end
            if (prev_lp) chk(!lp && rowclk, "R6 row clock after latch", {lp, rowclk}, 1);
            if (lp && !prev_lp) begin
                chk(col == NPL, "R6 shift clocks per line", col, NPL);
                chk(!sclk, "R6 latch apart from shift clock", sclk, 0);
                chk(first == (line == 0), "R7 first-line marker at latch", first, line == 0);
                chk(frame == exp_frame, "R8 frame polarity within frame", frame, exp_frame);
                col = 0;
            end
            if (rowclk && !prev_row) begin
                chk(first == (line == 0), "R7 first-line marker at row clock", first, line == 0);
                line++;
                lines_done++;
                if (line == LINES) begin
                    line = 0;
                    exp_frame = ~exp_frame;
                end
                chk(frame == exp_frame, "R8 frame toggle at last row", frame, exp_frame);
            end
            if (!lp && !rowclk) chk(!first, "R7 marker outside latch", first, 0);
            prev_sclk = sclk;
            prev_lp   = lp;
            prev_row  = rowclk;

            if (lines_done >= 3 * LINES) done = 1;
            if (cyc >= 150000) begin
                chk(0, "watchdog expired", cyc, 150000);
                done = 1;
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule